// File: doc/BRIEF.md
# PWM Leading-Edge Comparator Blanker

This block sits between an analog comparator output and the brake logic of a PWM timer. Each switching edge on a power stage produces ringing that can briefly trip a current-sense comparator. The blanker watches a small set of PWM outputs, and when a chosen kind of edge appears on any enabled one it holds the comparator signal low for a programmed number of clocks. A real fault that lasts longer than the window still reaches the brake logic. Short edge spikes do not.

Software selects which PWM outputs may start a window and whether rising edges, falling edges or both count. It also sets the window length and a master enable. With the master enable low, the comparator signal passes straight through. An edge that arrives while a window is open starts the window again at full length.

Top module: `pwm_edge_blanker`

## Requirements
- R1: After reset no window is open, and `cmp_o` equals `cmp_i`.
- R2: While `blank_en_i` is 0, `cmp_o` equals `cmp_i` in the same cycle and edges have no effect. Dropping the enable also closes any open window, so re-enabling leaves no residual blanking.
- R3: With `trig_mode_i` = 2'd0, only a 0-to-1 change on an enabled PWM input opens a window.
- R4: With `trig_mode_i` = 2'd1, only a 1-to-0 change on an enabled PWM input opens a window.
- R5: With `trig_mode_i` = 2'd2, a change in either direction on an enabled PWM input opens a window.
- R6: With `trig_mode_i` = 2'd3, no edge opens a window.
- R7: Bit i of `src_en_i` allows `pwm_i[i]` to open a window. Inputs whose bit is 0 are ignored, and any combination of bits may be set.
- R8: An edge is seen by comparing each PWM input with its value one cycle earlier. The window covers exactly `blank_len_i` cycles, starting in the cycle after the edge cycle, and `cmp_o` is 0 throughout. The edge cycle itself is not blanked.
- R9: A `blank_len_i` of 0 produces no blanking.
- R10: A qualifying edge during an open window reloads the window to the full `blank_len_i`.
- R11: Outside any window, `cmp_o` equals `cmp_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwm_i | input | NUM_SRC | PWM outputs that may start a window |
| src_en_i | input | NUM_SRC | Per-input permission to start a window |
| trig_mode_i | input | 2 | Edge kind: 0 rising, 1 falling, 2 either, 3 none |
| blank_len_i | input | CNT_W | Window length in clock cycles |
| blank_en_i | input | 1 | Master enable for blanking |
| cmp_i | input | 1 | Raw comparator signal |
| cmp_o | output | 1 | Comparator signal after blanking |

## Verification
The bench uses the defaults: three PWM inputs and an 8-bit length. This lets every mix of source-enable bits be formed and every edge mode be paired with each input. Window lengths from 0 to 8 keep each measured window short. The bench also sets up a restart three cycles into a six-cycle window, which separates a reload from a plain continuation by a distinct count of blanked cycles.

// File: rtl/lebl_pkg.sv
package lebl_pkg;
  typedef enum logic [1:0] {
    TRIG_RISE = 2'd0,
    TRIG_FALL = 2'd1,
    TRIG_ANY  = 2'd2,
    TRIG_NONE = 2'd3
  } trig_mode_e;
endpackage

// File: rtl/lebl_edge_detect.sv
// One PWM input: remembers the previous value and reports a qualifying edge.
module lebl_edge_detect (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sig_i,
  input  logic                  allow_i,
  input  lebl_pkg::trig_mode_e  mode_i,
  output logic                  hit_o
);
  logic prev_q, prev_d;
  logic rise, fall;

  always_comb begin
    prev_d = sig_i;
    rise   = sig_i & ~prev_q;
    fall   = ~sig_i & prev_q;
    unique case (mode_i)
      lebl_pkg::TRIG_RISE: hit_o = allow_i & rise;
      lebl_pkg::TRIG_FALL: hit_o = allow_i & fall;
      lebl_pkg::TRIG_ANY:  hit_o = allow_i & (rise | fall);
      default:             hit_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= prev_d;
  end
endmodule

// File: rtl/lebl_window_ctr.sv
// Down-counter holding the remaining blanked cycles.
module lebl_window_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             active_o
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_we;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_we = 1'b0;
    if (!enable_i) begin
      cnt_d  = ZERO;
      cnt_we = (cnt_q != ZERO);
    end else if (load_i) begin
      cnt_d  = len_i;
      cnt_we = 1'b1;
    end else if (cnt_q != ZERO) begin
      cnt_d  = cnt_q - ONE;
      cnt_we = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= ZERO;
    else if (cnt_we) cnt_q <= cnt_d;
  end

  assign cnt_o    = cnt_q;
  assign active_o = (cnt_q != ZERO);
endmodule

// File: rtl/pwm_edge_blanker.sv
module pwm_edge_blanker #(
  parameter int NUM_SRC = 3,
  parameter int CNT_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] pwm_i,
  input  logic [NUM_SRC-1:0] src_en_i,
  input  logic [1:0]         trig_mode_i,
  input  logic [CNT_W-1:0]   blank_len_i,
  input  logic               blank_en_i,
  input  logic               cmp_i,
  output logic               cmp_o
);
  lebl_pkg::trig_mode_e mode;
  logic [NUM_SRC-1:0]   src_hit;
  logic                 trig_hit;
  logic [CNT_W-1:0]     win_cnt;
  logic                 win_active;

  assign mode = lebl_pkg::trig_mode_e'(trig_mode_i);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    lebl_edge_detect u_edge (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sig_i   (pwm_i[g]),
      .allow_i (src_en_i[g]),
      .mode_i  (mode),
      .hit_o   (src_hit[g])
    );
  end

  assign trig_hit = |src_hit;

  lebl_window_ctr #(.CNT_W(CNT_W)) u_win (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (blank_en_i),
    .load_i   (trig_hit),
    .len_i    (blank_len_i),
    .cnt_o    (win_cnt),
    .active_o (win_active)
  );

  always_comb begin
    if (blank_en_i && win_active) cmp_o = 1'b0;
    else                          cmp_o = cmp_i;
  end
endmodule

// File: rtl/lebl_blank_checker.sv
module lebl_blank_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       trig_mode_i,
  input logic [CNT_W-1:0] blank_len_i,
  input logic             blank_en_i,
  input logic             cmp_i,
  input logic             cmp_o,
  input logic             trig_hit,
  input logic [CNT_W-1:0] win_cnt
);
  assert_bypass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blank_en_i |-> (cmp_o == cmp_i));

  assert_disable_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blank_en_i |=> (win_cnt == '0));

  assert_reserved_mode_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_mode_i == 2'd3) |-> !trig_hit);

  assert_window_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_en_i && win_cnt != '0) |-> !cmp_o);

  assert_countdown_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_en_i && !trig_hit && win_cnt != '0) |=> (win_cnt == $past(win_cnt) - CNT_W'(1)));

  assert_reload_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_en_i && trig_hit) |=> (win_cnt == $past(blank_len_i)));

  assert_idle_pass_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_cnt == '0) |-> (cmp_o == cmp_i));
endmodule

bind pwm_edge_blanker lebl_blank_checker #(.CNT_W(CNT_W)) u_blank_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .trig_mode_i (trig_mode_i),
  .blank_len_i (blank_len_i),
  .blank_en_i  (blank_en_i),
  .cmp_i       (cmp_i),
  .cmp_o       (cmp_o),
  .trig_hit    (trig_hit),
  .win_cnt     (win_cnt)
);

// File: tb/test_pwm_edge_blanker.sv
`timescale 1ns/1ps
module test_pwm_edge_blanker;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_SRC = 3;
  localparam int CNT_W   = 8;

  logic               clk;
  logic               rst_n;
  logic [NUM_SRC-1:0] pwm;
  logic [NUM_SRC-1:0] src_en;
  logic [1:0]         mode;
  logic [CNT_W-1:0]   len;
  logic               en;
  logic               cmp_in;
  logic               cmp_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  pwm_edge_blanker #(.NUM_SRC(NUM_SRC), .CNT_W(CNT_W)) i_pwm_edge_blanker (
    .clk_i(clk), .rst_ni(rst_n), .pwm_i(pwm), .src_en_i(src_en),
    .trig_mode_i(mode), .blank_len_i(len), .blank_en_i(en),
    .cmp_i(cmp_in), .cmp_o(cmp_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Counts consecutive blanked cycles starting at the next sample point.
  task automatic count_blank(output int n);
    bit stop;
    n = 0;
    stop = 0;
    for (int i = 0; i < 300 && !stop; i++) begin
      @(negedge clk);
      if (cmp_out === 1'b0) n++;
      else stop = 1;
    end
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  // Drive a new PWM vector; the edge cycle must pass, then count the window.
  task automatic edge_window(input logic [NUM_SRC-1:0] nv, input int exp, input string req);
    int n;
    @(posedge clk); #1 pwm = nv;
    @(negedge clk);
    chk(cmp_out === 1'b1, {req, " edge cycle not blanked"}, int'(cmp_out), 1);
    count_blank(n);
    chk(n == exp, {req, " blanked cycles"}, n, exp);
  endtask

  task automatic t_reset();
    cmp_in = 1'b1;
    @(negedge clk);
    chk(cmp_out === 1'b1, "R1 pass high after reset", int'(cmp_out), 1);
    cmp_in = 1'b0;
    @(negedge clk);
    chk(cmp_out === 1'b0, "R1 pass low after reset", int'(cmp_out), 0);
    cmp_in = 1'b1;
    @(negedge clk);
    chk(cmp_out === 1'b1, "R11 idle follows input", int'(cmp_out), 1);
  endtask

  task automatic t_rising();
    en = 1; mode = 2'd0; src_en = 3'b001; len = 8'd5; settle();
    edge_window(3'b001, 5, "R3 R8 rising");
    settle();
    edge_window(3'b000, 0, "R3 falling ignored");
  endtask

  task automatic t_falling();
    mode = 2'd1; len = 8'd4; settle();
    edge_window(3'b001, 0, "R4 rising ignored");
    settle();
    edge_window(3'b000, 4, "R4 falling");
  endtask

  task automatic t_both();
    mode = 2'd2; len = 8'd3; settle();
    edge_window(3'b001, 3, "R5 rise");
    settle();
    edge_window(3'b000, 3, "R5 fall");
  endtask

  task automatic t_reserved();
    mode = 2'd3; len = 8'd5; settle();
    edge_window(3'b001, 0, "R6 rise");
    settle();
    edge_window(3'b000, 0, "R6 fall");
  endtask

  task automatic t_mask();
    mode = 2'd0; len = 8'd2; src_en = 3'b100; settle();
    edge_window(3'b001, 0, "R7 masked input 0");
    settle();
    edge_window(3'b101, 2, "R7 enabled input 2");
    settle();
    pwm = 3'b000; settle();
    src_en = 3'b011;
    edge_window(3'b010, 2, "R7 enabled input 1");
    settle();
    edge_window(3'b110, 0, "R7 masked input 2");
    pwm = 3'b000; settle();
  endtask

  task automatic t_zero_len();
    mode = 2'd2; src_en = 3'b111; len = 8'd0; settle();
    edge_window(3'b001, 0, "R9 zero length");
    pwm = 3'b000; settle();
  endtask

  task automatic t_restart();
    int n;
    mode = 2'd2; src_en = 3'b001; len = 8'd6; settle();
    @(posedge clk); #1 pwm = 3'b001;
    repeat (4) @(negedge clk);
    @(posedge clk); #1 pwm = 3'b000;
    @(negedge clk);
    chk(cmp_out === 1'b0, "R10 old window still open", int'(cmp_out), 0);
    count_blank(n);
    chk(n == 6, "R10 window reloaded", n, 6);
    settle();
  endtask

  task automatic t_disable();
    int n;
    mode = 2'd2; src_en = 3'b111; len = 8'd5; en = 1'b0; settle();
    edge_window(3'b001, 0, "R2 disabled edge");
    cmp_in = 1'b0;
    @(negedge clk);
    chk(cmp_out === 1'b0, "R2 disabled pass low", int'(cmp_out), 0);
    cmp_in = 1'b1;
    en = 1'b1; len = 8'd8; settle();
    @(posedge clk); #1 pwm = 3'b000;
    @(negedge clk);
    @(negedge clk);
    chk(cmp_out === 1'b0, "R8 window open before disable", int'(cmp_out), 0);
    @(posedge clk); #1 en = 1'b0;
    @(negedge clk);
    chk(cmp_out === 1'b1, "R2 disable passes through", int'(cmp_out), 1);
    @(posedge clk); #1 en = 1'b1;
    @(negedge clk);
    chk(cmp_out === 1'b1, "R2 no residual window", int'(cmp_out), 1);
    count_blank(n);
    chk(n == 0, "R2 stays clear", n, 0);
  endtask

  initial begin
    rst_n = 1'b0; pwm = '0; src_en = '0; mode = 2'd0; len = '0; en = 1'b0; cmp_in = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_rising();
    t_falling();
    t_both();
    t_reserved();
    t_mask();
    t_zero_len();
    t_restart();
    t_disable();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end
endmodule